// File: doc/BRIEF.md
# Searchable In-Order Hazard Scoreboard

This block keeps a record of the destination registers of instructions that have passed decode but have not yet committed. Decode pushes one entry per instruction. The entry holds a register index and a flag. The flag says whether the instruction writes a register at all. Entries leave in program order when the oldest instruction commits. The hazard scoreboard always holds exactly one entry for each instruction in flight, so the pairing between pushes and pops never slips.

Two search ports work side by side. Each port takes an optional source operand and raises a hit when any live entry names the same register. The fetch stage can therefore test both operands of one instruction in a single cycle. A build-time mode selects the ordering within a cycle:
- **Pipelined ordering:** a commit is applied before that cycle's searches and push. A consumer of the committing instruction does not stall, and a full queue can accept a push while it pops.
- **Conflict-free ordering:** searches see the state as it stood at the start of the cycle.

Top module: `hazard_scoreboard`

## Requirements
- R1: A search port reports a hit only when its source flag is 1 and a live entry has its destination flag at 1 with an equal 5-bit index. A search with flag 0 never hits, and an empty scoreboard never hits.
- R2: Every accepted push creates an entry, even when the destination flag is 0. Such an entry never matches, but it occupies a slot and is consumed by one pop.
- R3: A pop removes the oldest entry, so entries retire in the order they were pushed.
- R4: The two search ports are independent. In the same cycle, one port may hit while the other misses.
- R5: In pipelined ordering, the entry that a pop removes in a cycle is already invisible to that cycle's searches.
- R6: In conflict-free ordering, an entry being popped still produces hits during that cycle. It stops producing hits from the next cycle.
- R7: The same destination index may sit in several entries. A search for it keeps hitting while any of those entries remains.
- R8: `full` is 1 exactly when DEPTH entries are held. A push while full and without a pop is dropped and leaves the contents unchanged.
- R9: In pipelined ordering, a push while full is accepted when a pop happens in the same cycle. The queue stays full with the new entry youngest.
- R10: A pop on an empty scoreboard changes nothing and raises `pop_err` in that cycle.
- R11: A synchronous active-low reset empties the scoreboard.
- R12: A push is not visible to searches in its own cycle. It hits from the following cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_en | input | 1 | Decode pushes an instruction's entry |
| push_has_dst | input | 1 | The pushed instruction writes a register |
| push_dst | input | 5 | Destination register index |
| pop_en | input | 1 | Oldest instruction commits |
| qa_vld | input | 1 | Search port A source is present |
| qa_idx | input | 5 | Search port A source index |
| qb_vld | input | 1 | Search port B source is present |
| qb_idx | input | 5 | Search port B source index |
| hit_a | output | 1 | Port A matches a live destination |
| hit_b | output | 1 | Port B matches a live destination |
| full | output | 1 | All DEPTH slots are occupied |
| pop_err | output | 1 | Pop requested while empty |

## Verification
The hardest situation to reach is a pop, a push and two searches in the same cycle on a full queue that holds duplicate indices and entries without a destination. Only there do same-cycle masking, the bypass for a full queue and the persistence of duplicates interact. The stimulus table fills a four-deep scoreboard with a duplicated index and an entry without a destination. It then drains the queue one pop at a time while searching for the index being retired and the next one. It also refills the queue and issues a combined pop-and-push while full. A second, one-deep instance with conflict-free ordering shows that a search still hits during the pop cycle.

// File: rtl/sb_pkg.sv
// Package sb_pkg
// Holds the types that the scoreboard modules share.
// Assumes that register indices are SB_IDX_W bits wide across the whole core.
package sb_pkg;
    localparam int SB_IDX_W = 5;

    typedef struct packed {
        logic                has_dst;
        logic [SB_IDX_W-1:0] idx;
    } sb_entry_t;
endpackage

// File: rtl/sb_ptr_ctrl.sv
// Module sb_ptr_ctrl
// Manages occupancy, the head and tail pointers and the live-slot mask of a
// circular queue. It decides whether a push or pop request takes effect.
// Assumes DEPTH >= 1. In pipelined ordering, a push into a full queue is let
// through when a pop is accepted in the same cycle.
module sb_ptr_ctrl #(
    parameter int DEPTH     = 1,
    parameter bit PIPELINED = 1'b1,
    parameter int PTR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             push_do,
    output logic             pop_do,
    output logic [PTR_W-1:0] tail,
    output logic [PTR_W-1:0] head,
    output logic [CNT_W-1:0] occ,
    output logic [DEPTH-1:0] live,
    output logic             full,
    output logic             pop_err
);
    // Advances a pointer by one slot, wrapping at DEPTH.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic empty;

    // Decodes the occupancy flags and which requests are accepted.
    always_comb begin
        empty   = (occ == '0);
        full    = (occ == CNT_W'(DEPTH));
        pop_do  = pop_req && !empty;
        pop_err = pop_req && empty;
        push_do = push_req && (!full || (PIPELINED && pop_do));
    end

    // Updates the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
            occ  <= '0;
        end else begin
            if (push_do) tail <= bump(tail);
            if (pop_do)  head <= bump(head);
            case ({push_do, pop_do})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_live
        // Marks slot i live when its distance from head is below occupancy.
        always_comb begin
            int off;
            off = i - int'(head);
            if (off < 0) off = off + DEPTH;
            live[i] = (off < int'(occ));
        end
    end
endmodule

// File: rtl/sb_store.sv
// Module sb_store
// Storage for the scoreboard entries, one register per slot.
// Assumes the controller only writes a slot that is free or being freed.
// Reset clears the destination flags.
module sb_store #(
    parameter int DEPTH = 1,
    parameter int PTR_W = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [PTR_W-1:0]              wr_ptr,
    input  sb_pkg::sb_entry_t             wr_ent,
    output sb_pkg::sb_entry_t [DEPTH-1:0] ents
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Captures the pushed entry into slot i when the tail points at it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ents[i] <= '0;
            end else if (wr_en && (wr_ptr == PTR_W'(i))) begin
                ents[i] <= wr_ent;
            end
        end
    end
endmodule

// File: rtl/sb_match.sv
// Module sb_match
// One search port. It compares an optional source index against every
// entry selected by a visibility mask. The result is purely combinational.
// Assumes the mask already excludes free slots and any slot popped this
// cycle under pipelined ordering.
module sb_match #(
    parameter int DEPTH = 1
) (
    input  sb_pkg::sb_entry_t [DEPTH-1:0]   ents,
    input  logic [DEPTH-1:0]                vis,
    input  logic                            q_vld,
    input  logic [sb_pkg::SB_IDX_W-1:0]     q_idx,
    output logic                            hit
);
    logic [DEPTH-1:0] slot_hit;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        // Flags slot i when it is visible, has a destination and the index matches.
        always_comb slot_hit[i] = vis[i] && ents[i].has_dst && (ents[i].idx == q_idx);
    end

    // Combines the per-slot results, gated by the source flag.
    always_comb hit = q_vld && (|slot_hit);
endmodule

// File: rtl/hazard_scoreboard.sv
// Module hazard_scoreboard
// An in-order queue of the destination registers of instructions in flight,
// with two search ports. PIPELINED=1 applies a pop before the same cycle's
// searches and push. PIPELINED=0 lets searches see the state at the start
// of the cycle. Assumes each push is eventually paired with exactly one pop.
module hazard_scoreboard #(
    parameter int DEPTH     = 1,
    parameter bit PIPELINED = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_en,
    input  logic       push_has_dst,
    input  logic [4:0] push_dst,
    input  logic       pop_en,
    input  logic       qa_vld,
    input  logic [4:0] qa_idx,
    input  logic       qb_vld,
    input  logic [4:0] qb_idx,
    output logic       hit_a,
    output logic       hit_b,
    output logic       full,
    output logic       pop_err
);
    import sb_pkg::*;

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int NPORT = 2;

    logic                  push_do, pop_do;
    logic [PTR_W-1:0]      tail, head;
    logic [CNT_W-1:0]      occ;
    logic [DEPTH-1:0]      live, head_sel, vis;
    sb_entry_t [DEPTH-1:0] ents;
    sb_entry_t             new_ent;
    logic [NPORT-1:0]      q_vld, hits;
    logic [SB_IDX_W-1:0]   q_idx [NPORT];

    sb_ptr_ctrl #(.DEPTH(DEPTH), .PIPELINED(PIPELINED), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push_req(push_en), .pop_req(pop_en),
        .push_do(push_do), .pop_do(pop_do), .tail(tail), .head(head),
        .occ(occ), .live(live), .full(full), .pop_err(pop_err)
    );

    // Forms the entry to store from the decode inputs.
    always_comb new_ent = '{has_dst: push_has_dst, idx: push_dst};

    sb_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(push_do), .wr_ptr(tail),
        .wr_ent(new_ent), .ents(ents)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_head
        // Selects the slot that a pop this cycle retires.
        always_comb head_sel[i] = pop_do && (head == PTR_W'(i));
    end

    if (PIPELINED) begin : g_pipe_vis
        // Hides the retiring slot from this cycle's searches.
        always_comb vis = live & ~head_sel;
    end else begin : g_cf_vis
        // Searches see every slot occupied at the start of the cycle.
        always_comb vis = live;
    end

    // Gathers the two search ports into arrays for the port generate.
    always_comb begin
        q_vld    = {qb_vld, qa_vld};
        q_idx[0] = qa_idx;
        q_idx[1] = qb_idx;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        sb_match #(.DEPTH(DEPTH)) u_match (
            .ents(ents), .vis(vis), .q_vld(q_vld[p]), .q_idx(q_idx[p]), .hit(hits[p])
        );
    end

    // Drives the hit outputs from the per-port results.
    always_comb begin
        hit_a = hits[0];
        hit_b = hits[1];
    end
endmodule

// File: rtl/hazard_scoreboard_chk.sv
// Module hazard_scoreboard_chk
// Temporal checks on the scoreboard ports and its occupancy count.
// It is attached to every hazard_scoreboard instance by the bind statement below.
module hazard_scoreboard_chk #(
    parameter int DEPTH     = 1,
    parameter bit PIPELINED = 1'b1,
    parameter int CNT_W     = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_en,
    input logic             pop_en,
    input logic             qa_vld,
    input logic             qb_vld,
    input logic             hit_a,
    input logic             hit_b,
    input logic             full,
    input logic             pop_err,
    input logic [CNT_W-1:0] occ
);
    // R1
    no_src_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!qa_vld |-> !hit_a) and (!qb_vld |-> !hit_b));

    // R1
    empty_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> (!hit_a && !hit_b));

    // R10
    empty_pop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && occ == '0) |-> pop_err);

    // R10
    empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && !push_en && occ == '0) |=> (occ == '0));

    // R2
    push_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && !full && !pop_en) |=> (occ == $past(occ) + 1'b1));

    // R8
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_en && !pop_en) |=> (full && $stable(occ)));

    // R9
    full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (PIPELINED && full && push_en && pop_en) |=> full);
endmodule

bind hazard_scoreboard hazard_scoreboard_chk #(
    .DEPTH(DEPTH), .PIPELINED(PIPELINED), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .pop_en(pop_en),
    .qa_vld(qa_vld), .qb_vld(qb_vld), .hit_a(hit_a), .hit_b(hit_b),
    .full(full), .pop_err(pop_err), .occ(occ)
);

// File: tb/test_hazard_scoreboard.sv
module test_hazard_scoreboard;
    typedef struct packed {
        logic       pe, ph;
        logic [4:0] pd;
        logic       po;
        logic       av;
        logic [4:0] ai;
        logic       bv;
        logic [4:0] bi;
        logic       ea, eb, ef, ee;
    } vec_t;

    localparam int NV = 20;
    // Fields: push_en, has_dst, dst, pop, qa_vld, qa_idx, qb_vld, qb_idx | hit_a, hit_b, full, pop_err
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,5'd0, 1'b1, 1'b1,5'd3,  1'b1,5'd0,  1'b0,1'b0,1'b0,1'b1},
        '{1'b1,1'b1,5'd3, 1'b0, 1'b1,5'd3,  1'b0,5'd0,  1'b0,1'b0,1'b0,1'b0},
        '{1'b1,1'b0,5'd3, 1'b0, 1'b1,5'd3,  1'b0,5'd3,  1'b1,1'b0,1'b0,1'b0},
        '{1'b1,1'b1,5'd5, 1'b0, 1'b1,5'd5,  1'b1,5'd4,  1'b0,1'b0,1'b0,1'b0},
        '{1'b1,1'b1,5'd3, 1'b0, 1'b1,5'd5,  1'b1,5'd3,  1'b1,1'b1,1'b0,1'b0},
        '{1'b1,1'b1,5'd7, 1'b0, 1'b1,5'd7,  1'b1,5'd3,  1'b0,1'b1,1'b1,1'b0},
        '{1'b0,1'b0,5'd0, 1'b0, 1'b1,5'd7,  1'b1,5'd3,  1'b0,1'b1,1'b1,1'b0},
        '{1'b0,1'b0,5'd0, 1'b1, 1'b1,5'd3,  1'b1,5'd5,  1'b1,1'b1,1'b1,1'b0},
        '{1'b0,1'b0,5'd0, 1'b1, 1'b1,5'd3,  1'b1,5'd0,  1'b1,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,5'd0, 1'b1, 1'b1,5'd5,  1'b1,5'd3,  1'b0,1'b1,1'b0,1'b0},
        '{1'b1,1'b1,5'd9, 1'b0, 1'b1,5'd9,  1'b1,5'd3,  1'b0,1'b1,1'b0,1'b0},
        '{1'b1,1'b1,5'd10,1'b0, 1'b1,5'd9,  1'b0,5'd0,  1'b1,1'b0,1'b0,1'b0},
        '{1'b1,1'b1,5'd11,1'b0, 1'b1,5'd10, 1'b0,5'd0,  1'b1,1'b0,1'b0,1'b0},
        '{1'b1,1'b1,5'd12,1'b1, 1'b1,5'd12, 1'b1,5'd3,  1'b0,1'b0,1'b1,1'b0},
        '{1'b0,1'b0,5'd0, 1'b0, 1'b1,5'd12, 1'b1,5'd9,  1'b1,1'b1,1'b1,1'b0},
        '{1'b0,1'b0,5'd0, 1'b1, 1'b1,5'd9,  1'b1,5'd10, 1'b0,1'b1,1'b1,1'b0},
        '{1'b0,1'b0,5'd0, 1'b1, 1'b1,5'd10, 1'b1,5'd11, 1'b0,1'b1,1'b0,1'b0},
        '{1'b0,1'b0,5'd0, 1'b1, 1'b1,5'd11, 1'b1,5'd12, 1'b0,1'b1,1'b0,1'b0},
        '{1'b0,1'b0,5'd0, 1'b1, 1'b1,5'd12, 1'b1,5'd12, 1'b0,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,5'd0, 1'b1, 1'b1,5'd12, 1'b0,5'd0,  1'b0,1'b0,1'b0,1'b1}
    };
    localparam string VTAG [NV] = '{"R10","R12","R1","R12","R4","R8","R8","R7","R2","R5",
                                    "R12","R3","R3","R9","R9","R3","R3","R3","R3","R10"};

    logic clk = 1'b0;
    logic rst_n;
    logic pe, ph, po, av, bv;
    logic [4:0] pd, ai, bi;
    logic ha, hb, fl, pr;
    logic c_pe, c_ph, c_po, c_av, c_bv;
    logic [4:0] c_pd, c_ai, c_bi;
    logic c_ha, c_hb, c_fl, c_pr;
    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    hazard_scoreboard #(.DEPTH(4), .PIPELINED(1'b1)) i_hazard_scoreboard (
        .clk(clk), .rst_n(rst_n), .push_en(pe), .push_has_dst(ph), .push_dst(pd),
        .pop_en(po), .qa_vld(av), .qa_idx(ai), .qb_vld(bv), .qb_idx(bi),
        .hit_a(ha), .hit_b(hb), .full(fl), .pop_err(pr)
    );

    hazard_scoreboard #(.DEPTH(1), .PIPELINED(1'b0)) i_hazard_scoreboard_cf (
        .clk(clk), .rst_n(rst_n), .push_en(c_pe), .push_has_dst(c_ph), .push_dst(c_pd),
        .pop_en(c_po), .qa_vld(c_av), .qa_idx(c_ai), .qb_vld(c_bv), .qb_idx(c_bi),
        .hit_a(c_ha), .hit_b(c_hb), .full(c_fl), .pop_err(c_pr)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic idle_all();
        {pe, ph, pd, po, av, ai, bv, bi} = '0;
        {c_pe, c_ph, c_pd, c_po, c_av, c_ai, c_bv, c_bi} = '0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle_all();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        av = 1'b1; ai = 5'd0; bv = 1'b1; bi = 5'd31;
        c_av = 1'b1; c_ai = 5'd0;
        #5;
        // R11 reset state
        chk("R11", "reset hit_a", ha, 1'b0);
        chk("R11", "reset hit_b", hb, 1'b0);
        chk("R11", "reset full", fl, 1'b0);
        chk("R11", "reset cf full", c_fl, 1'b0);
        chk("R11", "reset cf hit", c_ha, 1'b0);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            pe = VECS[v].pe; ph = VECS[v].ph; pd = VECS[v].pd; po = VECS[v].po;
            av = VECS[v].av; ai = VECS[v].ai; bv = VECS[v].bv; bi = VECS[v].bi;
            #5;
            chk(VTAG[v], $sformatf("vec %0d hit_a", v), ha, VECS[v].ea);
            chk(VTAG[v], $sformatf("vec %0d hit_b", v), hb, VECS[v].eb);
            chk(VTAG[v], $sformatf("vec %0d full", v), fl, VECS[v].ef);
            chk(VTAG[v], $sformatf("vec %0d pop_err", v), pr, VECS[v].ee);
        end

        // R6 conflict-free ordering: push 4 into the one-deep instance
        @(negedge clk);
        idle_all();
        c_pe = 1'b1; c_ph = 1'b1; c_pd = 5'd4;
        @(negedge clk);
        c_pe = 1'b0;
        c_av = 1'b1; c_ai = 5'd4;
        #5;
        chk("R8", "cf full after one push", c_fl, 1'b1);
        chk("R6", "cf hit before pop", c_ha, 1'b1);
        @(negedge clk);
        c_po = 1'b1;
        c_pe = 1'b1; c_ph = 1'b1; c_pd = 5'd6;
        c_bv = 1'b1; c_bi = 5'd6;
        #5;
        chk("R6", "cf hit during pop cycle", c_ha, 1'b1);
        chk("R12", "cf same-cycle push unseen", c_hb, 1'b0);
        @(negedge clk);
        c_po = 1'b0; c_pe = 1'b0;
        #5;
        chk("R6", "cf hit after pop", c_ha, 1'b0);
        chk("R8", "cf push blocked while full", c_hb, 1'b0);
        chk("R8", "cf empty after pop", c_fl, 1'b0);

        // R11 reset in mid-run empties the main instance
        @(negedge clk);
        idle_all();
        pe = 1'b1; ph = 1'b1; pd = 5'd8;
        @(negedge clk);
        pe = 1'b0;
        av = 1'b1; ai = 5'd8;
        #5;
        chk("R12", "entry visible next cycle", ha, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        chk("R11", "hit cleared by reset", ha, 1'b0);
        chk("R11", "full cleared by reset", fl, 1'b0);

        @(negedge clk);
        finish_run();
    end
endmodule